// File: doc/BRIEF.md
# Receive Character FIFO with Fill-Level Interrupt

This block is the receive-side character store of a serial port. The receiver hands it one 12-bit entry at a time: eight data bits, error bits, and a break marker at bit 10. A read of the data register takes the oldest entry off the front. The block keeps the storage, a wrapping read position and a fill count. From these it produces empty and full status, a raw receive interrupt and a flag that tells the receiver whether one more character fits.

Two configuration inputs set the behaviour. The line-control FIFO-enable bit selects one of two depths: the full 16-entry buffer, or a single holding slot. A 3-bit field taken from the level-select register sets the fill level at which the interrupt is raised. The interrupt is level-matched and hysteretic. It is raised by the push that makes the count equal to the level, and it is dropped only by a pop that leaves the count one below the level. A break event is stored as its own entry.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the count is 0, the read position is 0, empty is 1, full is 0, the interrupt is 0, and every stored entry reads as 0.
- R2: With `fifo_mode_i` = 1 a push is accepted while the count is below 16. With `fifo_mode_i` = 0 a push is accepted only while the count is 0. `can_accept_o` shows this condition. A push that is not accepted leaves the count, the data and the flags unchanged.
- R3: Entries are returned in arrival order. `rd_data_o` always shows the entry at the 4-bit read position. A pop advances that position modulo 16, and a write goes to the slot at read position plus count, modulo 16.
- R4: The interrupt level is 4 × `rx_lvl_sel_i` when `fifo_mode_i` = 1 (this field is bits 5:3 of the level-select register) and 1 when `fifo_mode_i` = 0. A change on either input takes effect in the same cycle and does not alter the count or the stored entries.
- R5: An accepted push whose resulting count equals the level sets `rx_irq_o` on the next clock.
- R6: A pop whose resulting count equals the level minus one clears `rx_irq_o`, including a pop of an empty buffer when the level is 1. Any other pop leaves `rx_irq_o` unchanged.
- R7: `rx_empty_o` is 1 exactly when the count is 0. An accepted push sets `rx_full_o` when `fifo_mode_i` = 0 or the count reaches 16. Every pop clears `rx_full_o` unless a push in the same cycle sets it again.
- R8: A pop of an empty buffer leaves the count at 0 and the read position unchanged, so `rd_data_o` keeps showing the stale entry.
- R9: `brk_i` stores the entry 0x400 (bit 10 set). When `brk_i` and `push_i` occur in the same cycle only the break entry is stored and the character is lost.
- R10: When a pop and a push occur in the same cycle, the pop is applied first. Acceptance is judged on the count before the pop, so a push into a full buffer, or into an occupied single slot, is dropped even though a pop happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_i | input | 1 | Line-control FIFO enable: 1 = 16 entries, 0 = one slot |
| rx_lvl_sel_i | input | 3 | Receive interrupt level field (level = 4 × value in FIFO mode) |
| push_i | input | 1 | Receiver offers one character entry |
| push_entry_i | input | 12 | Character entry: data, error and break bits |
| brk_i | input | 1 | Line break detected; stores 0x400 |
| pop_i | input | 1 | Data-register read: remove the front entry |
| rd_data_o | output | 12 | Entry at the read position |
| rx_count_o | output | 5 | Number of stored entries |
| rx_empty_o | output | 1 | Receive buffer empty |
| rx_full_o | output | 1 | Receive buffer full |
| rx_irq_o | output | 1 | Raw receive interrupt |
| can_accept_o | output | 1 | One more entry would be accepted now |

## Verification
The two events that collide are a pop and a push in the same cycle, and, on the push side, a break and a character together. The bench drives these pairs on purpose at partial fill, at 16 entries, and in single-slot mode with the slot occupied. It also drives them densely in a long random run with changing configuration. In every cycle a behavioural model applies the pop first and then the push, judging acceptance on the count from before the pop. The design's count, flags, interrupt and front entry are compared against that model on the next falling edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ENTRY_W = 12;
    localparam int BRK_BIT = 10;

    localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_BIT;

    typedef struct packed {
        logic               en;
        logic [ENTRY_W-1:0] val;
    } wr_req_t;

endpackage

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int SEL_W = 3,
    localparam int LVL_W = SEL_W + 2
) (
    input  logic             fifo_mode_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [LVL_W-1:0] level_o
);

    always_comb begin
        if (fifo_mode_i) begin
            level_o = {sel_i, 2'b00};
        end else begin
            level_o = LVL_W'(1);
        end
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_req_t            wr_i,
    input  logic [PTR_W-1:0]   wr_slot_i,
    input  logic [PTR_W-1:0]   rd_pos_i,
    output logic [ENTRY_W-1:0] rd_data_o
);

    logic [DEPTH-1:0][ENTRY_W-1:0] mem_d;
    logic [DEPTH-1:0][ENTRY_W-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_i.en) begin
            mem_d[wr_slot_i] = wr_i.val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_pos_i];

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode_i,
    input  logic [LVL_W-1:0]   level_i,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] push_entry_i,
    input  logic               brk_i,
    input  logic               pop_i,
    output wr_req_t            wr_o,
    output logic [PTR_W-1:0]   wr_slot_o,
    output logic [PTR_W-1:0]   rd_pos_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               empty_o,
    output logic               full_o,
    output logic               irq_o,
    output logic               accept_o
);

    typedef struct packed {
        logic [PTR_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic             empty;
        logic             full;
        logic             irq;
    } ctl_t;

    ctl_t st_d;
    ctl_t st_q;

    logic [CMP_W-1:0] lvl_ext;

    assign lvl_ext  = CMP_W'(level_i);
    assign accept_o = fifo_mode_i ? (st_q.cnt < CNT_W'(DEPTH)) : (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        wr_o.en   = (push_i | brk_i) & accept_o;
        wr_o.val  = brk_i ? BRK_ENTRY : push_entry_i;

        // removal is applied before insertion
        if (pop_i) begin
            st_d.full = 1'b0;
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                st_d.pos = st_q.pos + PTR_W'(1);
            end
            if (st_d.cnt == '0) begin
                st_d.empty = 1'b1;
            end
            if (CMP_W'(st_d.cnt) == lvl_ext - CMP_W'(1)) begin
                st_d.irq = 1'b0;
            end
        end

        wr_slot_o = st_d.pos + st_d.cnt[PTR_W-1:0];

        if (wr_o.en) begin
            st_d.cnt   = st_d.cnt + CNT_W'(1);
            st_d.empty = 1'b0;
            if (!fifo_mode_i || st_d.cnt == CNT_W'(DEPTH)) begin
                st_d.full = 1'b1;
            end
            if (CMP_W'(st_d.cnt) == lvl_ext) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos   <= '0;
            st_q.cnt   <= '0;
            st_q.empty <= 1'b1;
            st_q.full  <= 1'b0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_pos_o = st_q.pos;
    assign count_o  = st_q.cnt;
    assign empty_o  = st_q.empty;
    assign full_o   = st_q.full;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEL_W = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int LVL_W = SEL_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode_i,
    input  logic [SEL_W-1:0]   rx_lvl_sel_i,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] push_entry_i,
    input  logic               brk_i,
    input  logic               pop_i,
    output logic [ENTRY_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]   rx_count_o,
    output logic               rx_empty_o,
    output logic               rx_full_o,
    output logic               rx_irq_o,
    output logic               can_accept_o
);

    logic [LVL_W-1:0] level;
    wr_req_t          wr_req;
    logic [PTR_W-1:0] wr_slot;
    logic [PTR_W-1:0] rd_pos;

    rxf_level #(
        .SEL_W(SEL_W)
    ) u_level (
        .fifo_mode_i(fifo_mode_i),
        .sel_i      (rx_lvl_sel_i),
        .level_o    (level)
    );

    rxf_ctrl #(
        .DEPTH(DEPTH),
        .LVL_W(LVL_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode_i),
        .level_i     (level),
        .push_i      (push_i),
        .push_entry_i(push_entry_i),
        .brk_i       (brk_i),
        .pop_i       (pop_i),
        .wr_o        (wr_req),
        .wr_slot_o   (wr_slot),
        .rd_pos_o    (rd_pos),
        .count_o     (rx_count_o),
        .empty_o     (rx_empty_o),
        .full_o      (rx_full_o),
        .irq_o       (rx_irq_o),
        .accept_o    (can_accept_o)
    );

    rxf_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_req),
        .wr_slot_i(wr_slot),
        .rd_pos_i (rd_pos),
        .rd_data_o(rd_data_o)
    );

endmodule

// File: rtl/rx_char_fifo_chk.sv
module rx_char_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int SEL_W = 3,
    parameter int ENTRY_W = 12,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_mode_i,
    input logic [SEL_W-1:0]   rx_lvl_sel_i,
    input logic               push_i,
    input logic               brk_i,
    input logic               pop_i,
    input logic [ENTRY_W-1:0] rd_data_o,
    input logic [CNT_W-1:0]   rx_count_o,
    input logic               rx_empty_o,
    input logic               rx_full_o,
    input logic               rx_irq_o,
    input logic               can_accept_o
);

    int lvl;
    int cnt;
    assign lvl = fifo_mode_i ? 4 * int'(rx_lvl_sel_i) : 1;
    assign cnt = int'(rx_count_o);

    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty_o == (cnt == 0));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH);

    p_single_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode_i && cnt != 0) |-> !can_accept_o);

    p_drop_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_i || brk_i) && !can_accept_o && !pop_i) |=> $stable(rx_count_o));

    p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_i || brk_i) && can_accept_o && !pop_i && cnt + 1 == lvl) |=> rx_irq_o);

    p_pop_clears_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !brk_i) |=> !rx_full_o);

    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt == 0 && !push_i && !brk_i) |=> (rx_count_o == '0) && $stable(rd_data_o));

    p_break_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && can_accept_o && !pop_i && cnt == 0) |=> rd_data_o == ENTRY_W'(12'h400));

endmodule

bind rx_char_fifo rx_char_fifo_chk #(
    .DEPTH  (DEPTH),
    .SEL_W  (SEL_W),
    .ENTRY_W(rxf_pkg::ENTRY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode_i (fifo_mode_i),
    .rx_lvl_sel_i(rx_lvl_sel_i),
    .push_i      (push_i),
    .brk_i       (brk_i),
    .pop_i       (pop_i),
    .rd_data_o   (rd_data_o),
    .rx_count_o  (rx_count_o),
    .rx_empty_o  (rx_empty_o),
    .rx_full_o   (rx_full_o),
    .rx_irq_o    (rx_irq_o),
    .can_accept_o(can_accept_o)
);

// File: tb/tb_rx_char_fifo.sv
module tb_rx_char_fifo;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_mode = 1'b0;
    logic [2:0]  lvl_sel = 3'd0;
    logic        push = 1'b0;
    logic [11:0] ent = 12'd0;
    logic        brk = 1'b0;
    logic        pop = 1'b0;
    logic [11:0] rd_data;
    logic [4:0]  count;
    logic        empty, full, irq, can_acc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_char_fifo dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode),
        .rx_lvl_sel_i(lvl_sel),
        .push_i      (push),
        .push_entry_i(ent),
        .brk_i       (brk),
        .pop_i       (pop),
        .rd_data_o   (rd_data),
        .rx_count_o  (count),
        .rx_empty_o  (empty),
        .rx_full_o   (full),
        .rx_irq_o    (irq),
        .can_accept_o(can_acc)
    );

    function automatic void chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endfunction

    // behavioural reference model
    int m_mem[16];
    int m_pos, m_cnt;
    bit m_empty, m_full, m_irq, m_acc;

    function automatic int m_lvl();
        return fifo_mode ? 4 * int'(lvl_sel) : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_pos = 0; m_cnt = 0; m_empty = 1; m_full = 0; m_irq = 0;
        end else begin
            m_acc = fifo_mode ? (m_cnt < 16) : (m_cnt == 0);
            if (pop) begin
                m_full = 0;
                if (m_cnt > 0) begin
                    m_cnt--;
                    m_pos = (m_pos + 1) % 16;
                end
                if (m_cnt == 0) m_empty = 1;
                if (m_cnt == m_lvl() - 1) m_irq = 0;
            end
            if ((push || brk) && m_acc) begin
                m_mem[(m_pos + m_cnt) % 16] = brk ? 'h400 : int'(ent);
                m_cnt++;
                m_empty = 0;
                if (!fifo_mode || m_cnt == 16) m_full = 1;
                if (m_cnt == m_lvl()) m_irq = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 model rd_data", int'(rd_data), m_mem[m_pos]);
            chk("R2 model count", int'(count), m_cnt);
            chk("R7 model empty", int'(empty), int'(m_empty));
            chk("R7 model full", int'(full), int'(m_full));
            chk("R5 model irq", int'(irq), int'(m_irq));
            chk("R2 model can_accept", int'(can_acc),
                fifo_mode ? int'(m_cnt < 16) : int'(m_cnt == 0));
        end
    end

    task automatic cyc(bit pu, bit br, bit po, logic [11:0] d);
        push = pu; brk = br; pop = po; ent = d;
        @(posedge clk);
        #2;
        push = 1'b0; brk = 1'b0; pop = 1'b0;
    endtask

    task automatic do_push(logic [11:0] d);
        cyc(1'b1, 1'b0, 1'b0, d);
    endtask

    task automatic do_pop();
        cyc(1'b0, 1'b0, 1'b1, 12'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int stale;
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rd_data", int'(rd_data), 0);

        // level 8 in FIFO mode
        fifo_mode = 1'b1; lvl_sel = 3'd2;
        for (int i = 0; i < 10; i++) begin
            do_push(12'h100 + 12'(i));
            if (i == 6) chk("R5 irq below level", int'(irq), 0);
            if (i == 7) chk("R5 irq at level", int'(irq), 1);
        end
        chk("R3 head", int'(rd_data), 'h100);
        do_pop(); do_pop();
        chk("R6 irq kept at level", int'(irq), 1);
        do_pop();
        chk("R6 irq cleared at level-1", int'(irq), 0);
        for (int j = 0; j < 9; j++) do_push(12'h200 + 12'(j));
        chk("R7 full at 16", int'(full), 1);
        chk("R2 no accept at 16", int'(can_acc), 0);
        do_push(12'h0AA);
        chk("R2 dropped push count", int'(count), 16);
        for (int k = 0; k < 16; k++) begin
            chk("R3 order with wrap", int'(rd_data), (k < 7) ? ('h103 + k) : ('h200 + k - 7));
            do_pop();
        end
        chk("R7 empty after drain", int'(empty), 1);
        chk("R7 full after drain", int'(full), 0);
        stale = int'(rd_data);
        do_pop();
        chk("R8 empty pop count", int'(count), 0);
        chk("R8 empty pop stale data", int'(rd_data), stale);

        // level change with content
        do_push(12'h301); do_push(12'h302); do_push(12'h303);
        lvl_sel = 3'd1;
        #1;
        chk("R4 count kept on cfg change", int'(count), 3);
        chk("R4 head kept on cfg change", int'(rd_data), 'h301);
        do_push(12'h304);
        chk("R4 new level 4 raises irq", int'(irq), 1);
        lvl_sel = 3'd4;
        do_pop(); do_pop(); do_pop(); do_pop();
        chk("R6 irq kept when level-1 not hit", int'(irq), 1);
        fifo_mode = 1'b0;
        do_pop();
        chk("R6 empty pop clears irq at level 1", int'(irq), 0);

        // single-slot mode
        do_push(12'h041);
        chk("R7 full in single slot", int'(full), 1);
        chk("R5 irq in single slot", int'(irq), 1);
        chk("R2 single slot refuses", int'(can_acc), 0);
        do_push(12'h042);
        chk("R2 single slot drop count", int'(count), 1);
        chk("R2 single slot keeps data", int'(rd_data), 'h041);
        do_pop();
        chk("R7 single slot pop full", int'(full), 0);
        chk("R6 single slot pop irq", int'(irq), 0);

        // break entries
        fifo_mode = 1'b1; lvl_sel = 3'd2;
        cyc(1'b0, 1'b1, 1'b0, 12'd0);
        chk("R9 break entry", int'(rd_data), 'h400);
        cyc(1'b1, 1'b1, 1'b0, 12'h055);
        chk("R9 break with char count", int'(count), 2);
        do_pop();
        chk("R9 break wins over char", int'(rd_data), 'h400);
        do_pop();

        // simultaneous pop and push
        do_push(12'h011); do_push(12'h022); do_push(12'h033);
        cyc(1'b1, 1'b0, 1'b1, 12'h044);
        chk("R10 pop+push count", int'(count), 3);
        chk("R10 pop+push head", int'(rd_data), 'h022);
        for (int i = 0; i < 13; i++) do_push(12'h500 + 12'(i));
        cyc(1'b1, 1'b0, 1'b1, 12'h0EE);
        chk("R10 full pop+push dropped", int'(count), 15);
        chk("R7 pop clears full", int'(full), 0);
        for (int i = 0; i < 15; i++) do_pop();
        fifo_mode = 1'b0;
        do_push(12'h061);
        cyc(1'b1, 1'b0, 1'b1, 12'h062);
        chk("R10 single slot pop+push dropped", int'(count), 0);

        // random traffic with changing configuration
        for (int n = 0; n < 3000; n++) begin
            if (n % 64 == 0) begin
                fifo_mode = 1'($urandom_range(0, 3) != 0);
                lvl_sel = 3'($urandom_range(0, 7));
            end
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0),
                1'($urandom_range(0, 2) == 0), 12'($urandom_range(0, 4095)));
        end

        @(posedge clk);
        #2;
        finish_run();
    end

endmodule